// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Unit

This block holds the status byte of a small serial flash slave and decides which modifying instructions are allowed to start. It watches the serial clock, the active-low select and the serial data input, all sampled through synchronisers on the system clock. Eight-bit instructions arrive MSB first and are captured on rising serial-clock edges. An instruction takes effect only when select rises after a whole number of bytes. The read-status instruction returns the status byte MSB first on falling edges. It keeps returning the byte for as long as select stays low. Each repeat is a coherent snapshot taken at its byte boundary.

Acceptance of write-status, page-program, sector-erase and bulk-erase depends on four things: the write-enable latch, the two block-protect bits, the status-lock bit and the write-protect pin. An accepted operation starts a busy counter, which stands in for the array cycle. While the counter runs, the in-progress bit reads 1. When it expires, the write-enable latch clears. The serial link has no back-pressure: the master owns the clock, and the unit always keeps pace at the documented oversampling ratio (at least six system clocks per serial half period). All pins are plain control and status levels.

Top module: `spi_sr_unit`

## Requirements
- R1: Status byte, MSB to LSB, is {lock, 0, 0, 0, prot[1], prot[0], wel, wip}; it reads 00h and the serial output is 0 after reset.
- R2: After opcode 05h, the status byte is driven MSB first, one bit per falling serial-clock edge, and repeats every 8 clocks while select stays low; each repeat is sampled at its first bit.
- R3: Opcode 06h alone sets wel and opcode 04h alone clears it.
- R4: An accepted write-status (01h), page-program (02h), sector-erase (D8h) or bulk-erase (C7h) sets wip for BUSY_CYCLES system clocks; when wip falls, wel reads 0.
- R5: With wel = 0, opcodes 01h, 02h, D8h and C7h are ignored and the status is unchanged.
- R6: Write-status (opcode plus one data byte) loads lock from data bit 7 and prot[1:0] from data bits 3:2; data bits 6:4 are discarded and read back as 0.
- R7: Page-program (opcode, 3 address bytes, at least 1 data byte) and sector-erase (opcode, 3 address bytes) are rejected when the two top array-address bits fall in the protected area: prot 00 none, 01 top bits 11, 10 top bit 1, 11 all.
- R8: Bulk-erase is accepted only when prot is 00.
- R9: With lock = 1 and wp_n low, write-status is rejected and lock and prot do not change.
- R10: While wip = 1, every instruction other than read-status is ignored.
- R11: An instruction ends only on a rising select after a whole number of bytes, with the exact byte count for its opcode; a partial byte or a wrong count makes it be ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from master, idles low |
| cs_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data in, sampled on rising sck |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out, changes on falling sck |

## Verification
The busy counter can expire during a continuous status read. In that cycle, wip falls and wel clears while the read path is mid-byte. The bench starts a write-status and then holds select low through many status bytes. Each returned byte must be either the complete busy form or the complete idle form, with no mixture of the two. Once the idle form appears it must persist, and it must appear before the read ends.

// File: rtl/spi_sr_pkg.sv
`timescale 1ns/1ps
package spi_sr_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;

  // protected area for a given prot setting and top two address bits
  function automatic logic area_locked(input logic [1:0] prot, input logic [1:0] top);
    case (prot)
      2'b00:   area_locked = 1'b0;
      2'b01:   area_locked = (top == 2'b11);
      2'b10:   area_locked = top[1];
      default: area_locked = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_sr_link.sv
`timescale 1ns/1ps
module spi_sr_link #(
  parameter int ARRAY_AW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] status,
  output logic       miso,
  output logic       commit,
  output logic [7:0] op,
  output logic [2:0] nbytes,
  output logic [2:0] sr_new,
  output logic [1:0] addr_top
);
  import spi_sr_pkg::*;
  // address is 3 bytes, MSB first; locate the byte and bit of the top two array bits
  localparam int TOPBIT  = ARRAY_AW - 1;
  localparam int SEL_IDX = 3 - TOPBIT / 8;
  localparam int POS     = TOPBIT % 8;

  logic [2:0] sck_p, cs_p;
  logic [1:0] mosi_p;
  logic       sck_rise, sck_fall, cs_rise, sel;
  logic [2:0] bitcnt, bcnt, obit;
  logic [6:0] rx_sh;
  logic [7:0] rx_byte, op_q, snap;
  logic [2:0] sr_new_q;
  logic [1:0] top_q;
  logic       rd_on, miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sck};
      cs_p   <= {cs_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  assign sel      = ~cs_p[1];
  assign sck_rise = sel & sck_p[1] & ~sck_p[2];
  assign sck_fall = sel & ~sck_p[1] & sck_p[2];
  assign cs_rise  = cs_p[1] & ~cs_p[2];
  assign rx_byte  = {rx_sh, mosi_p[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0; bcnt <= '0; obit <= '0; rx_sh <= '0;
      op_q <= '0; snap <= '0; sr_new_q <= '0; top_q <= '0;
      rd_on <= 1'b0; miso_q <= 1'b0;
    end else if (!sel) begin
      bitcnt <= '0; bcnt <= '0; obit <= '0;
      rd_on <= 1'b0; miso_q <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_sh  <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          if (bcnt == 3'd0) begin
            op_q  <= rx_byte;
            rd_on <= (rx_byte == OP_RDSR);
          end
          if (bcnt == 3'd1) sr_new_q <= {rx_byte[7], rx_byte[3:2]};
          if (bcnt == 3'(SEL_IDX)) top_q <= rx_byte[POS -: 2];
          if (bcnt != 3'd7) bcnt <= bcnt + 3'd1;
        end
      end
      if (sck_fall && rd_on) begin
        if (obit == 3'd0) begin
          snap   <= status;
          miso_q <= status[7];
        end else begin
          miso_q <= snap[~obit];
        end
        obit <= obit + 3'd1;
      end
    end
  end

  assign commit   = cs_rise & (bitcnt == 3'd0) & (bcnt != 3'd0);
  assign op       = op_q;
  assign nbytes   = bcnt;
  assign sr_new   = sr_new_q;
  assign addr_top = top_q;
  assign miso     = miso_q;

  // R2
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && sel) |=> $stable(miso_q));
endmodule

// File: rtl/spi_sr_busy.sv
`timescale 1ns/1ps
module spi_sr_busy #(
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  // R10
  busy_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/spi_sr_ctrl.sv
`timescale 1ns/1ps
module spi_sr_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic [7:0] op,
  input  logic [2:0] nbytes,
  input  logic [2:0] sr_new,
  input  logic [1:0] addr_top,
  input  logic       wp_n,
  input  logic       busy,
  input  logic       busy_done,
  output logic       busy_start,
  output logic [7:0] status
);
  import spi_sr_pkg::*;
  logic       wel, lock;
  logic [1:0] prot;
  logic       set_wel, clr_wel, wr_sr, hw_lock;

  assign hw_lock = lock & ~wp_n;

  always_comb begin
    set_wel = 1'b0; clr_wel = 1'b0; wr_sr = 1'b0; busy_start = 1'b0;
    if (commit && !busy) begin
      case (op)
        OP_WREN: set_wel = (nbytes == 3'd1);
        OP_WRDI: clr_wel = (nbytes == 3'd1);
        OP_WRSR: begin
          wr_sr      = (nbytes == 3'd2) && wel && !hw_lock;
          busy_start = wr_sr;
        end
        OP_PP:   busy_start = (nbytes >= 3'd5) && wel && !area_locked(prot, addr_top);
        OP_SE:   busy_start = (nbytes == 3'd4) && wel && !area_locked(prot, addr_top);
        OP_BE:   busy_start = (nbytes == 3'd1) && wel && (prot == 2'b00);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; lock <= 1'b0; prot <= 2'b00;
    end else begin
      if (busy_done)    wel <= 1'b0;
      else if (set_wel) wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
      if (wr_sr) begin
        lock <= sr_new[2];
        prot <= sr_new[1:0];
      end
    end
  end

  assign status = {lock, 3'b000, prot, wel, busy};

  // R4
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R5
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |-> wel);
  // R8
  bulk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_start && op == OP_BE) |-> (prot == 2'b00));
  // R9
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && lock && !wp_n) |=> $stable({lock, prot}));
  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && busy && !busy_done) |=> $stable(status));
endmodule

// File: rtl/spi_sr_unit.sv
`timescale 1ns/1ps
module spi_sr_unit #(
  parameter int BUSY_CYCLES = 1000,
  parameter int ARRAY_AW    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  logic       commit, busy, busy_done, busy_start;
  logic [7:0] op, status;
  logic [2:0] nbytes, sr_new;
  logic [1:0] addr_top;

  spi_sr_link #(.ARRAY_AW(ARRAY_AW)) u_link (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .status(status), .miso(miso), .commit(commit), .op(op),
    .nbytes(nbytes), .sr_new(sr_new), .addr_top(addr_top)
  );

  spi_sr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .commit(commit), .op(op), .nbytes(nbytes),
    .sr_new(sr_new), .addr_top(addr_top), .wp_n(wp_n), .busy(busy),
    .busy_done(busy_done), .busy_start(busy_start), .status(status)
  );

  spi_sr_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(busy_start), .busy(busy), .done(busy_done)
  );
endmodule

// File: tb/spi_sr_unit_bench.sv
`timescale 1ns/1ps
module spi_sr_unit_bench;
  localparam int BUSY = 400;
  localparam int HP   = 6;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso;
  int   nchk = 0, nfail = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  spi_sr_unit #(.BUSY_CYCLES(BUSY), .ARRAY_AW(16)) u_spi_sr_unit (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .wp_n(wp_n), .miso(miso)
  );

  // {opcode, address middle byte, data byte, wp_n, expected status}
  localparam int NV = 32;
  localparam logic [32:0] VEC [NV] = '{
    {8'h01, 8'h00, 8'h8C, 1'b1, 8'h00}, // R5 write-status without wel
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h02}, // R3
    {8'h04, 8'h00, 8'h00, 1'b1, 8'h00}, // R3
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h02},
    {8'h01, 8'h00, 8'h84, 1'b1, 8'h84}, // R6 R4
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h86},
    {8'hC7, 8'h00, 8'h00, 1'b1, 8'h86}, // R8 rejected
    {8'hD8, 8'hC0, 8'h00, 1'b1, 8'h86}, // R7 upper quarter locked
    {8'hD8, 8'h80, 8'h00, 1'b1, 8'h84}, // R7 below quarter accepted
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h86},
    {8'h01, 8'h00, 8'h00, 1'b0, 8'h86}, // R9 locked by pin
    {8'h01, 8'h00, 8'h00, 1'b1, 8'h00}, // R9 pin released
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h02},
    {8'h02, 8'hC0, 8'h55, 1'b1, 8'h00}, // R7 no protection
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h02},
    {8'h01, 8'h00, 8'h08, 1'b1, 8'h08},
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h0A},
    {8'h02, 8'h80, 8'hAA, 1'b1, 8'h0A}, // R7 upper half locked
    {8'h02, 8'h40, 8'hAA, 1'b1, 8'h08}, // R7 lower half accepted
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h0A},
    {8'h01, 8'h00, 8'hF0, 1'b1, 8'h80}, // R6 bits 6:4 dropped
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h82},
    {8'h01, 8'h00, 8'h0C, 1'b0, 8'h82}, // R9
    {8'h01, 8'h00, 8'h0C, 1'b1, 8'h0C},
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h0E},
    {8'hD8, 8'h00, 8'h00, 1'b1, 8'h0E}, // R7 whole array
    {8'hC7, 8'h00, 8'h00, 1'b1, 8'h0E}, // R8
    {8'h01, 8'h00, 8'h00, 1'b1, 8'h00},
    {8'h06, 8'h00, 8'h00, 1'b1, 8'h02},
    {8'hC7, 8'h00, 8'h00, 1'b1, 8'h00}, // R8 accepted
    {8'h02, 8'hC0, 8'h11, 1'b1, 8'h00}, // R5 program without wel
    {8'hD8, 8'h00, 8'h00, 1'b1, 8'h00}  // R5 erase without wel
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - n; i--) begin
      mosi = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic spi_begin();
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic spi_end();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [7:0] d;
    spi_begin();
    spi_byte(8'h05, d);
    spi_byte(8'h00, s);
    spi_end();
  endtask

  task automatic send_op(input logic [7:0] op, input logic [7:0] ahi, input logic [7:0] dat);
    logic [7:0] d;
    spi_begin();
    spi_byte(op, d);
    if (op == 8'h01) spi_byte(dat, d);
    if (op == 8'hD8 || op == 8'h02) begin
      spi_byte(8'h00, d); spi_byte(ahi, d); spi_byte(8'h00, d);
      if (op == 8'h02) spi_byte(dat, d);
    end
    spi_end();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] s, d;
    bit seen_idle, mixed;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 miso after reset", {7'd0, miso}, 8'h00);
    read_status(s);
    check("R1 status after reset", s, 8'h00);

    for (int v = 0; v < NV; v++) begin
      wp_n = VEC[v][8];
      send_op(VEC[v][32:25], VEC[v][24:17], VEC[v][16:9]);
      repeat (BUSY + 20) @(negedge clk);
      read_status(s);
      check($sformatf("table vector %0d (R3..R9)", v), s, VEC[v][7:0]);
    end
    wp_n = 1'b1;

    // R11 partial byte after write enable opcode
    spi_begin(); spi_byte(8'h06, d); spi_bits(8'hF0, 4, d); spi_end();
    read_status(s);
    check("R11 partial byte ignored", s, 8'h00);
    // R11 wrong byte count
    spi_begin(); spi_byte(8'h06, d); spi_byte(8'h00, d); spi_end();
    read_status(s);
    check("R11 extra byte ignored", s, 8'h00);

    // R2 R4 continuous read across busy expiry
    send_op(8'h06, 8'h00, 8'h00);
    send_op(8'h01, 8'h00, 8'h84);
    seen_idle = 1'b0; mixed = 1'b0;
    spi_begin();
    spi_byte(8'h05, d);
    for (int k = 0; k < 10; k++) begin
      spi_byte(8'h00, s);
      if (k == 0) check("R2 first repeat busy form", s, 8'h87);
      if (s == 8'h84) seen_idle = 1'b1;
      else if (s != 8'h87 || seen_idle) mixed = 1'b1;
    end
    spi_end();
    check("R2 repeats coherent", {7'd0, mixed}, 8'h00);
    check("R4 wip fell and wel cleared", {7'd0, seen_idle}, 8'h01);

    // R10 write disable during busy is ignored
    send_op(8'h06, 8'h00, 8'h00);
    send_op(8'h01, 8'h00, 8'h00);
    send_op(8'h04, 8'h00, 8'h00);
    read_status(s);
    check("R10 wel kept while busy", s, 8'h03);
    repeat (BUSY) @(negedge clk);
    read_status(s);
    check("R4 after completion", s, 8'h00);

    finished = 1'b1;
    summary();
  end
endmodule